// File: doc/BRIEF.md
# Return Address Stack

This block predicts where function returns will land. Each time the front end sees a call, the address of the instruction that follows the call (call PC plus the instruction size) is pushed onto a small hardware last-in first-out store. When the front end predicts a return, it asserts a pop and receives the newest stored address, with a valid flag, combinationally in the same cycle. The entry is then removed.

A return that fetch could not classify in time is steered by the branch target buffer instead. When decode later recognises it as a return, it raises a correction strobe. That strobe pops the stack exactly like a predicted return, and the target it returns is used to fix the fetch path.

The capacity is a parameter. Once the call depth exceeds it, the stack wraps and overwrites its oldest entry. The newest entries stay intact, so only the deepest returns are mispredicted. A pop on an empty stack gives no target.

Top module: `call_return_stack`

## Requirements
- R1: After synchronous active-low reset the stack is empty, so the first pop request gives `tgt_vld_o` low and `tgt_o` zero.
- R2: A push stores `call_pc_i + INSTR_BYTES` (default 4), computed modulo 2^ADDR_W. A later pop request presents that value on `tgt_o` with `tgt_vld_o` high in the same cycle as the request.
- R3: Entries come back in reverse order of their pushes: with N ≤ DEPTH pushes, N pops return them newest first, and pop N+1 finds the stack empty.
- R4: The stack never holds more than DEPTH entries. After N > DEPTH pushes, pops return the newest DEPTH addresses newest first, and the next pop finds the stack empty because the oldest entries were overwritten.
- R5: A pop request on an empty stack gives `tgt_vld_o` low and `tgt_o` zero, and leaves the stack empty. A push that follows it is returned normally.
- R6: A push and a pop request in the same cycle on a non-empty stack present the current top on `tgt_o` and then replace that top with the new return address, so the depth is unchanged. On an empty stack the same pair gives no target and acts as a plain push.
- R7: The correction strobe `fix_i` is a pop request with the same target and valid behaviour as `ret_i`.
- R8: `ret_i` and `fix_i` high in the same cycle remove only one entry.
- R9: In a cycle with no pop request (`ret_i` and `fix_i` both low), `tgt_vld_o` is low and `tgt_o` is zero.
- R10: A call at PC 0xFFFFFFFC stores return address 0x00000000, because the addition wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | Call seen: push its return address |
| call_pc_i | input | ADDR_W | PC of the call instruction |
| ret_i | input | 1 | Predicted return: read and pop the top |
| fix_i | input | 1 | Decode recognised a return that was not predicted: read and pop the top |
| tgt_o | output | ADDR_W | Predicted return target (zero when not valid) |
| tgt_vld_o | output | 1 | Target on `tgt_o` is valid |

## Verification
A push and a pop can land in the same cycle. The pop may come from `ret_i`, from `fix_i`, or from both at once. The bench causes these coincidences on purpose: it pairs a call with a return on an empty stack, on a partly filled stack and on a full one. A pseudo-random operation stream then mixes all eight combinations of the three strobes. Each cycle's output is judged against a queue model in the bench, in which the pop is read before the push is applied. That order means the old top must appear and the depth must stay the same.

// File: rtl/ras_pkg.sv
// Package: shared types for the return address stack.
// Assumes: nothing beyond IEEE 1800-2017.
package ras_pkg;

    // Kind of stack update resolved for one cycle
    typedef enum logic [1:0] {
        RAS_IDLE = 2'd0,
        RAS_PUSH = 2'd1,
        RAS_POP  = 2'd2,
        RAS_SWAP = 2'd3
    } ras_kind_e;

endpackage

// File: rtl/ras_ctrl.sv
// Module: ras_ctrl
// Tracks the top-of-stack index and the occupancy of a circular return
// stack. A push advances the top and saturates the occupancy, so an
// overflow overwrites the oldest slot. A pop retreats the top when the
// stack holds anything. A push with a pop replaces the top in place.
// Assumes: DEPTH >= 1; IW and CW are wide enough for DEPTH-1 and DEPTH.
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          wr_en_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [IW-1:0] top_idx_o,
    output logic [CW-1:0] occ_o,
    output logic          empty_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_OCC = CW'(DEPTH);

    logic [IW-1:0] top_q;
    logic [CW-1:0] occ_q;
    ras_kind_e     kind;

    // Next slot index with wrap at DEPTH
    function automatic logic [IW-1:0] idx_inc(input logic [IW-1:0] v);
        return (v == LAST_IDX) ? '0 : v + IW'(1);
    endfunction

    // Previous slot index with wrap at DEPTH
    function automatic logic [IW-1:0] idx_dec(input logic [IW-1:0] v);
        return (v == '0) ? LAST_IDX : v - IW'(1);
    endfunction

    assign empty_o = (occ_q == '0);

    // Resolve the requested operation against the current occupancy
    always_comb begin
        kind = RAS_IDLE;
        if (push_i && pop_i && !empty_o) begin
            kind = RAS_SWAP;
        end else if (push_i) begin
            kind = RAS_PUSH;
        end else if (pop_i && !empty_o) begin
            kind = RAS_POP;
        end
    end

    // Write port: push writes above the top, swap overwrites the top
    always_comb begin
        wr_en_o  = 1'b0;
        wr_idx_o = top_q;
        case (kind)
            RAS_PUSH: begin
                wr_en_o  = 1'b1;
                wr_idx_o = idx_inc(top_q);
            end
            RAS_SWAP: begin
                wr_en_o  = 1'b1;
                wr_idx_o = top_q;
            end
            default: begin
                wr_en_o  = 1'b0;
                wr_idx_o = top_q;
            end
        endcase
    end

    // Top pointer and occupancy registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            occ_q <= '0;
        end else begin
            case (kind)
                RAS_PUSH: begin
                    top_q <= idx_inc(top_q);
                    if (occ_q != FULL_OCC) begin
                        occ_q <= occ_q + CW'(1);
                    end
                end
                RAS_POP: begin
                    top_q <= idx_dec(top_q);
                    occ_q <= occ_q - CW'(1);
                end
                default: begin
                    top_q <= top_q;
                    occ_q <= occ_q;
                end
            endcase
        end
    end

    assign top_idx_o = top_q;
    assign occ_o     = occ_q;

endmodule

// File: rtl/ras_store.sv
// Module: ras_store
// Register file of DEPTH return addresses with one write port and one
// combinational read port. Every slot clears on reset.
// Assumes: wr_idx_i and rd_idx_i are below DEPTH.
module ras_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);

    logic [DEPTH-1:0][AW-1:0] slots;

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic [AW-1:0] val_q;

        // One slot: load when the write port selects it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en_i && (wr_idx_i == IW'(e))) begin
                val_q <= wr_data_i;
            end
        end

        assign slots[e] = val_q;
    end

    // Read mux over all slots
    always_comb begin
        rd_data_o = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (rd_idx_i == IW'(e)) begin
                rd_data_o = slots[e];
            end
        end
    end

endmodule

// File: rtl/ras_rdout.sv
// Module: ras_rdout
// Forms the prediction outputs. A target is valid only while a pop is
// requested and the stack holds an entry. The target is forced to zero
// otherwise.
// Assumes: rd_data_i is the current top entry.
module ras_rdout #(
    parameter int AW = 32
) (
    input  logic          pop_req_i,
    input  logic          empty_i,
    input  logic [AW-1:0] rd_data_i,
    output logic          vld_o,
    output logic [AW-1:0] tgt_o
);

    // Qualify the top entry with the pop request
    always_comb begin
        vld_o = pop_req_i && !empty_i;
        tgt_o = vld_o ? rd_data_i : '0;
    end

endmodule

// File: rtl/call_return_stack.sv
// Module: call_return_stack (top)
// Predicts function return targets. A call pushes call PC plus the
// instruction size. A predicted return or a decode correction pops the
// top and presents it in the same cycle. The store wraps on overflow.
// Assumes: at most one call per cycle; ret_i and fix_i together count
// as a single pop.
module call_return_stack #(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic [ADDR_W-1:0] call_pc_i,
    input  logic              ret_i,
    input  logic              fix_i,
    output logic [ADDR_W-1:0] tgt_o,
    output logic              tgt_vld_o
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic              pop_req;
    logic              wr_en;
    logic [IW-1:0]     wr_idx;
    logic [IW-1:0]     top_idx;
    logic [CW-1:0]     occ;
    logic              empty;
    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] top_data;

    // Either return source requests a single pop
    assign pop_req   = ret_i || fix_i;
    // Return address of the call, wrapping at the address width
    assign link_addr = call_pc_i + STEP;

    ras_ctrl #(
        .DEPTH (DEPTH),
        .IW    (IW),
        .CW    (CW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (call_i),
        .pop_i     (pop_req),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .top_idx_o (top_idx),
        .occ_o     (occ),
        .empty_o   (empty)
    );

    ras_store #(
        .DEPTH (DEPTH),
        .AW    (ADDR_W),
        .IW    (IW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (link_addr),
        .rd_idx_i  (top_idx),
        .rd_data_o (top_data)
    );

    ras_rdout #(
        .AW (ADDR_W)
    ) u_rdout (
        .pop_req_i (pop_req),
        .empty_i   (empty),
        .rd_data_i (top_data),
        .vld_o     (tgt_vld_o),
        .tgt_o     (tgt_o)
    );

endmodule

// File: rtl/ras_checker.sv
// Module: ras_checker
// Concurrent checks on the return address stack, bound to the top.
// Assumes: occ_i is the occupancy held by the control block.
module ras_checker #(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4,
    parameter int CW          = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_i,
    input logic [ADDR_W-1:0] call_pc_i,
    input logic              ret_i,
    input logic              fix_i,
    input logic [ADDR_W-1:0] tgt_o,
    input logic              tgt_vld_o,
    input logic [CW-1:0]     occ_i
);

    logic pop;
    logic armed_q;

    assign pop = ret_i || fix_i;

    // Set one cycle after reset release so $past sees post-reset values
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R2: the address pushed in the previous cycle comes back on a pop
    p_link_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(call_i && !ret_i && !fix_i) && pop)
        |-> (tgt_vld_o && tgt_o == $past(call_pc_i) + ADDR_W'(INSTR_BYTES)));

    // R4: occupancy never exceeds the capacity
    p_depth_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ_i <= CW'(DEPTH));

    // R4: a push on a full stack keeps it full
    p_full_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !pop && occ_i == CW'(DEPTH)) |=> (occ_i == CW'(DEPTH)));

    // R5: a pop on an empty stack gives no target and keeps it empty
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !call_i && occ_i == '0) |-> (!tgt_vld_o && tgt_o == '0));

    // R6: a push with a pop on a non-empty stack keeps the depth
    p_swap_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && pop && occ_i != '0) |=> (occ_i == $past(occ_i)));

    // R8: both pop sources together remove one entry
    p_single_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && fix_i && !call_i && occ_i != '0)
        |=> (occ_i == $past(occ_i) - CW'(1)));

    // R9: no pop request, no target
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |-> (!tgt_vld_o && tgt_o == '0));

endmodule

bind call_return_stack ras_checker #(
    .DEPTH       (DEPTH),
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .CW          (CW)
) u_ras_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_i    (call_i),
    .call_pc_i (call_pc_i),
    .ret_i     (ret_i),
    .fix_i     (fix_i),
    .tgt_o     (tgt_o),
    .tgt_vld_o (tgt_vld_o),
    .occ_i     (occ)
);

// File: tb/tb_call_return_stack.sv
// Bench for call_return_stack: directed sweeps and a pseudo-random
// stream, each compared against a bench-side queue model.
module tb_call_return_stack;

    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int STEP  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_i = 1'b0;
    logic [AW-1:0] call_pc_i = '0;
    logic          ret_i = 1'b0;
    logic          fix_i = 1'b0;
    logic [AW-1:0] tgt_o;
    logic          tgt_vld_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [AW-1:0] model [$];

    call_return_stack #(.DEPTH(DEPTH), .ADDR_W(AW), .INSTR_BYTES(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
        .ret_i(ret_i), .fix_i(fix_i), .tgt_o(tgt_o), .tgt_vld_o(tgt_vld_o)
    );

    always #4 clk = ~clk;

    // Compare outputs with expected values
    task automatic check(input string tag, input logic ev, input logic [AW-1:0] et);
        n_checks++;
        if (tgt_vld_o !== ev || tgt_o !== et) begin
            n_fails++;
            $display("FAIL %s: got vld=%0b tgt=%08h, expected vld=%0b tgt=%08h",
                     tag, tgt_vld_o, tgt_o, ev, et);
        end
    endtask

    // One cycle: drive at negedge, check, then advance the model
    task automatic step(input logic c, input logic [AW-1:0] pc,
                        input logic r, input logic f, input string tag);
        logic          ev;
        logic [AW-1:0] et;
        @(negedge clk);
        call_i = c; call_pc_i = pc; ret_i = r; fix_i = f;
        #1;
        ev = (r || f) && (model.size() > 0);
        et = ev ? model[model.size()-1] : '0;
        check(tag, ev, et);
        if (ev) void'(model.pop_back());
        if (c) begin
            model.push_back(pc + AW'(STEP));
            if (model.size() > DEPTH) void'(model.pop_front());
        end
    endtask

    task automatic drain(input string tag);
        while (model.size() > 0) step(1'b0, '0, 1'b1, 1'b0, tag);
        step(1'b0, '0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 idle and R1 empty after reset
        step(1'b0, '0, 1'b0, 1'b0, "R9 idle after reset");
        step(1'b0, '0, 1'b1, 1'b0, "R1 pop after reset");

        // R3/R4: fill to every depth up to beyond capacity, then drain
        for (int n = 0; n <= DEPTH + 3; n++) begin
            for (int i = 0; i < n; i++)
                step(1'b1, 32'h4000_0000 + AW'(n * 1024 + i * 16), 1'b0, 1'b0,
                     (n > DEPTH) ? "R4 overflow push" : "R3 push");
            for (int i = 0; i <= n; i++)
                step(1'b0, '0, (i % 2) == 0, (i % 2) == 1,
                     (n > DEPTH) ? "R4 overflow pop" : "R3 R7 pop order");
        end

        // R5: empty pop, then normal push and pop
        step(1'b0, '0, 1'b1, 1'b0, "R5 empty pop");
        step(1'b1, 32'h0000_1230, 1'b0, 1'b0, "R5 push after empty pop");
        step(1'b0, '0, 1'b1, 1'b0, "R5 R2 pop after empty pop");

        // R6: push with pop on partly filled, empty and full stacks
        step(1'b1, 32'h0000_A000, 1'b0, 1'b0, "R6 push A");
        step(1'b1, 32'h0000_B000, 1'b0, 1'b0, "R6 push B");
        step(1'b1, 32'h0000_C000, 1'b1, 1'b0, "R6 swap gives old top");
        drain("R6 drain after swap");
        step(1'b1, 32'h0000_D000, 1'b0, 1'b1, "R6 swap on empty");
        drain("R6 drain after empty swap");
        for (int i = 0; i < DEPTH; i++) step(1'b1, AW'(i * 32), 1'b0, 1'b0, "R6 fill");
        step(1'b1, 32'h0000_E000, 1'b1, 1'b1, "R6 R8 swap on full");
        drain("R6 drain full");

        // R8: both pop sources remove one entry
        step(1'b1, 32'h0000_0100, 1'b0, 1'b0, "R8 push");
        step(1'b1, 32'h0000_0200, 1'b0, 1'b0, "R8 push");
        step(1'b0, '0, 1'b1, 1'b1, "R8 dual pop");
        step(1'b0, '0, 1'b0, 1'b0, "R9 idle non-empty");
        drain("R8 remaining entry");

        // R10: address wrap
        step(1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0, "R10 push wrap");
        step(1'b0, '0, 1'b0, 1'b1, "R10 R7 wrapped target");

        // Mixed stream over all strobe combinations
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], {lfsr, lfsr[7:0], 8'h00}, lfsr[1] & lfsr[3],
                 lfsr[2] & lfsr[4], "R2 R6 R8 mixed stream");
        end
        drain("R3 final drain");

        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0; fix_i = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule